// File: doc/BRIEF.md
# DRAM Temperature Derating Monitor

This block watches the die temperature of LPDDR2 memory through the refresh-rate field of mode register 4. A poll timer counts refresh-interval ticks, and each time the programmed count elapses a small sequencer reads the field from chip select 0. When a second chip select is populated it also reads chip select 1. The two readings are merged into one temperature level. Codes below nominal are raised to nominal, and the reserved code is ignored.

The stored level decides which copy of three timing values drives the memory controller: the refresh control word and two timing words. Each word has a nominal and a derated copy. The block raises a sticky alert whenever the level changes. A rising level switches the timing set at once. A falling level, or the shutdown level, is only queued for a supervisor, which commits it later. Parts that are not rated for extended temperature turn any derate reading into a shutdown condition. A plain request/acknowledge port stands in for the mode-register read path of the memory.

Top module: `dram_derate_mon`

## Requirements
- R1: A read pass starts once every `poll_interval` pulses of `ref_tick`, counting only pulses that arrive while no pass is running. The first pass follows the `poll_interval`-th pulse after a zero interval. A `poll_interval` of 0 stops polling and clears the count.
- R2: `mr_req` stays high until `mr_ack`, and `mr_cs` does not change while it is high. `mr_rate[2:0]` is taken in the acknowledge cycle. Chip select 0 (`mr_cs`=0) is read first. Chip select 1 (`mr_cs`=1) is read only when `cs1_used` is 1.
- R3: With `cs1_used`=1, the merged code is the larger of the two readings. With `cs1_used`=0, it is the chip select 0 reading alone.
- R4: A merged code of 0, 1 or 2 is treated as level 3, the nominal level.
- R5: A merged code of 4, the reserved code, is discarded, and the stored level is kept.
- R6: With `ext_temp_ok`=0, a level of 5 or more is stored as 7. `shutdown` is high exactly while the stored level is 7.
- R7: `alert` goes high when a new level differs from the stored one, and only then. It stays high until an `alert_clr` pulse clears it (write one to clear). A new change in the same cycle wins over the clear.
- R8: A change to a higher level other than 7 is applied to the output set at once, and it clears `relax_pend`.
- R9: A change to a lower level, or to level 7, sets `relax_pend` and leaves the output set unchanged. A `defer_done` pulse then applies the stored level and clears `relax_pend`.
- R10: At applied level 5, only `out_refctl` takes its derated value. At applied level 6, `out_refctl`, `out_tim1` and `out_tim3` all take their derated values. At any other level all three take their nominal values.
- R11: With `is_lpddr2`=0, all three outputs take their nominal values, whatever the level.
- R12: After reset, `temp_level` is 3, `alert`, `relax_pend`, `shutdown` and `mr_req` are 0, and the outputs take their nominal values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One pulse per refresh interval |
| poll_interval | input | CNT_W | Ticks between read passes; 0 disables polling |
| cs1_used | input | 1 | Second chip select populated |
| ext_temp_ok | input | 1 | Part rated for extended temperature |
| is_lpddr2 | input | 1 | Attached device type allows derating |
| nom_refctl | input | REG_W | Nominal refresh control word |
| nom_tim1 | input | REG_W | Nominal timing word 1 |
| nom_tim3 | input | REG_W | Nominal timing word 3 |
| drt_refctl | input | REG_W | Derated refresh control word |
| drt_tim1 | input | REG_W | Derated timing word 1 |
| drt_tim3 | input | REG_W | Derated timing word 3 |
| mr_req | output | 1 | Mode-register read request |
| mr_cs | output | 1 | Chip select of the read (0 or 1) |
| mr_ack | input | 1 | Read acknowledge, data valid |
| mr_rate | input | 3 | Refresh-rate field returned by the read |
| alert_clr | input | 1 | Write-one-to-clear pulse for the alert |
| defer_done | input | 1 | Supervisor commit of a deferred level |
| temp_level | output | 3 | Stored temperature level |
| alert | output | 1 | Sticky level-change alert |
| relax_pend | output | 1 | Deferred level waiting for commit |
| shutdown | output | 1 | Stored level is the shutdown level |
| out_refctl | output | REG_W | Selected refresh control word |
| out_tim1 | output | REG_W | Selected timing word 1 |
| out_tim3 | output | REG_W | Selected timing word 3 |

## Verification
The assertions check these rules on every cycle: the request stays held until it is acknowledged, the stored level never takes codes 0 to 2 or 4, every level change leaves the alert set, a clear without a new change drops the alert, a rising level is applied in the next cycle, and a queued level leaves the applied set untouched until commit. Some behaviour only the bench scenarios can show. The bench sweeps every pair of chip-select codes under each combination of second-chip-select and extended-rating flags against an arithmetic model. That sweep is what shows the maximum merge, the clamp to nominal, the reserved-code hold, the shutdown conversion and which words are derated at each level. The bench also counts read passes against ticks for the poll interval, and it runs the non-LPDDR2 override.

// File: rtl/dtm_pkg.sv
package dtm_pkg;
   typedef logic [2:0] lvl_t;

   localparam lvl_t LVL_NOM    = 3'd3;
   localparam lvl_t LVL_RSVD   = 3'd4;
   localparam lvl_t LVL_DR_REF = 3'd5;
   localparam lvl_t LVL_DR_ALL = 3'd6;
   localparam lvl_t LVL_SHUT   = 3'd7;

   localparam int NUM_REGS = 3;
   localparam int IDX_REF  = 0;
   localparam int IDX_T1   = 1;
   localparam int IDX_T3   = 2;

   // lowest applied level at which a word switches to its derated copy
   function automatic lvl_t derate_floor(input int idx);
      return (idx == IDX_REF) ? LVL_DR_REF : LVL_DR_ALL;
   endfunction
endpackage

// File: rtl/dtm_poll_timer.sv
module dtm_poll_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic             busy,
   input  logic [CNT_W-1:0] interval,
   output logic             poll_go
);
   logic [CNT_W-1:0] cnt_q;
   logic             hit;

   assign hit     = (cnt_q >= interval - 1'b1);
   assign poll_go = (interval != '0) && ref_tick && !busy && hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt_q <= '0;
      else if (interval == '0)     cnt_q <= '0;
      else if (ref_tick && !busy)  cnt_q <= hit ? '0 : cnt_q + 1'b1;
   end

   AST_GO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      poll_go |-> !busy && (interval != '0)); // R1
endmodule

// File: rtl/dtm_mr_reader.sv
module dtm_mr_reader
   import dtm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic cs1_used,
   input  logic mr_ack,
   input  lvl_t mr_rate,
   output logic mr_req,
   output logic mr_cs,
   output logic busy,
   output logic rd_valid,
   output lvl_t rd_code
);
   typedef enum logic [1:0] {ST_IDLE, ST_CS0, ST_CS1} st_t;
   st_t  st_q;
   lvl_t code0_q;

   assign mr_req = (st_q != ST_IDLE);
   assign mr_cs  = (st_q == ST_CS1);
   assign busy   = mr_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         code0_q  <= LVL_NOM;
         rd_valid <= 1'b0;
         rd_code  <= LVL_NOM;
      end else begin
         rd_valid <= 1'b0;
         case (st_q)
            ST_IDLE: if (go) st_q <= ST_CS0;
            ST_CS0: if (mr_ack) begin
               code0_q <= mr_rate;
               if (cs1_used) st_q <= ST_CS1;
               else begin
                  st_q     <= ST_IDLE;
                  rd_valid <= 1'b1;
                  rd_code  <= mr_rate;
               end
            end
            ST_CS1: if (mr_ack) begin
               st_q     <= ST_IDLE;
               rd_valid <= 1'b1;
               rd_code  <= (mr_rate > code0_q) ? mr_rate : code0_q;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      mr_req && !mr_ack |=> mr_req && $stable(mr_cs)); // R2
endmodule

// File: rtl/dtm_level_ctl.sv
module dtm_level_ctl
   import dtm_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rd_valid,
   input  lvl_t rd_code,
   input  logic ext_temp_ok,
   input  logic alert_clr,
   input  logic defer_done,
   output lvl_t lvl_q,
   output lvl_t applied_q,
   output logic alert_q,
   output logic pend_q
);
   lvl_t clamped, cand;
   logic usable, changed, deferred;

   assign clamped  = (rd_code < LVL_NOM) ? LVL_NOM : rd_code;
   assign usable   = rd_valid && (clamped != LVL_RSVD);
   assign cand     = (!ext_temp_ok && clamped >= LVL_DR_REF) ? LVL_SHUT : clamped;
   assign changed  = usable && (cand != lvl_q);
   assign deferred = (cand < lvl_q) || (cand == LVL_SHUT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q     <= LVL_NOM;
         applied_q <= LVL_NOM;
         pend_q    <= 1'b0;
         alert_q   <= 1'b0;
      end else begin
         if (changed) begin
            lvl_q <= cand;
            if (deferred) pend_q <= 1'b1;
            else begin
               applied_q <= cand;
               pend_q    <= 1'b0;
            end
         end else if (defer_done && pend_q) begin
            applied_q <= lvl_q;
            pend_q    <= 1'b0;
         end
         if (changed)        alert_q <= 1'b1;
         else if (alert_clr) alert_q <= 1'b0;
      end
   end

   AST_LEVEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q >= LVL_NOM) && (lvl_q != LVL_RSVD)); // R4
   AST_CHANGE_ALERTS: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_q != $past(lvl_q)) |-> alert_q); // R7
   AST_ALERT_W1C: assert property (@(posedge clk) disable iff (!rst_n)
      alert_clr && !changed |=> !alert_q); // R7
   AST_RISE_NOW: assert property (@(posedge clk) disable iff (!rst_n)
      changed && !deferred |=> (applied_q == lvl_q) && !pend_q); // R8
   AST_DEFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q && !defer_done && !(changed && !deferred) |=> $stable(applied_q)); // R9
endmodule

// File: rtl/dtm_reg_sel.sv
module dtm_reg_sel
   import dtm_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int NREG  = NUM_REGS
) (
   input  lvl_t                       applied,
   input  logic                       is_lpddr2,
   input  logic [NREG-1:0][REG_W-1:0] nom,
   input  logic [NREG-1:0][REG_W-1:0] drt,
   output logic [NREG-1:0][REG_W-1:0] sel
);
   for (genvar g = 0; g < NREG; g++) begin : g_word
      localparam lvl_t FLOOR = derate_floor(g);
      logic use_drt;
      assign use_drt = is_lpddr2 && (applied >= FLOOR) && (applied <= LVL_DR_ALL);
      assign sel[g]  = use_drt ? drt[g] : nom[g];
   end
endmodule

// File: rtl/dram_derate_mon.sv
module dram_derate_mon
   import dtm_pkg::*;
#(
   parameter int REG_W = 32,
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_tick,
   input  logic [CNT_W-1:0] poll_interval,
   input  logic             cs1_used,
   input  logic             ext_temp_ok,
   input  logic             is_lpddr2,
   input  logic [REG_W-1:0] nom_refctl,
   input  logic [REG_W-1:0] nom_tim1,
   input  logic [REG_W-1:0] nom_tim3,
   input  logic [REG_W-1:0] drt_refctl,
   input  logic [REG_W-1:0] drt_tim1,
   input  logic [REG_W-1:0] drt_tim3,
   output logic             mr_req,
   output logic             mr_cs,
   input  logic             mr_ack,
   input  logic [2:0]       mr_rate,
   input  logic             alert_clr,
   input  logic             defer_done,
   output logic [2:0]       temp_level,
   output logic             alert,
   output logic             relax_pend,
   output logic             shutdown,
   output logic [REG_W-1:0] out_refctl,
   output logic [REG_W-1:0] out_tim1,
   output logic [REG_W-1:0] out_tim3
);
   if (REG_W < 1) begin : g_bad_regw
      $error("REG_W must be positive");
   end
   if (CNT_W < 2) begin : g_bad_cntw
      $error("CNT_W must be at least 2");
   end

   logic poll_go, busy, rd_valid, alert_q, pend_q;
   lvl_t rd_code, lvl_q, applied_q;
   logic [NUM_REGS-1:0][REG_W-1:0] nom_set, drt_set, sel_set;

   dtm_poll_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .busy(busy),
      .interval(poll_interval), .poll_go(poll_go));

   dtm_mr_reader u_reader (
      .clk(clk), .rst_n(rst_n), .go(poll_go), .cs1_used(cs1_used),
      .mr_ack(mr_ack), .mr_rate(mr_rate), .mr_req(mr_req), .mr_cs(mr_cs),
      .busy(busy), .rd_valid(rd_valid), .rd_code(rd_code));

   dtm_level_ctl u_level (
      .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_code(rd_code),
      .ext_temp_ok(ext_temp_ok), .alert_clr(alert_clr), .defer_done(defer_done),
      .lvl_q(lvl_q), .applied_q(applied_q), .alert_q(alert_q), .pend_q(pend_q));

   assign nom_set[IDX_REF] = nom_refctl;
   assign nom_set[IDX_T1]  = nom_tim1;
   assign nom_set[IDX_T3]  = nom_tim3;
   assign drt_set[IDX_REF] = drt_refctl;
   assign drt_set[IDX_T1]  = drt_tim1;
   assign drt_set[IDX_T3]  = drt_tim3;

   dtm_reg_sel #(.REG_W(REG_W), .NREG(NUM_REGS)) u_sel (
      .applied(applied_q), .is_lpddr2(is_lpddr2),
      .nom(nom_set), .drt(drt_set), .sel(sel_set));

   assign out_refctl = sel_set[IDX_REF];
   assign out_tim1   = sel_set[IDX_T1];
   assign out_tim3   = sel_set[IDX_T3];
   assign temp_level = lvl_q;
   assign alert      = alert_q;
   assign relax_pend = pend_q;
   assign shutdown   = (lvl_q == LVL_SHUT);

   AST_SHUT_NONEXT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown) |-> alert && relax_pend); // R6
endmodule

// File: tb/dram_derate_mon_bench.sv
`timescale 1ns/1ps
module dram_derate_mon_bench;
   localparam int REG_W = 32;
   localparam int CNT_W = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic ref_tick = 1'b0;
   logic [CNT_W-1:0] poll_interval = '0;
   logic cs1_used = 1'b0, ext_temp_ok = 1'b1, is_lpddr2 = 1'b1;
   logic [REG_W-1:0] nom_refctl = 32'hA000_0010, nom_tim1 = 32'hA000_0011, nom_tim3 = 32'hA000_0013;
   logic [REG_W-1:0] drt_refctl = 32'hD000_0010, drt_tim1 = 32'hD000_0011, drt_tim3 = 32'hD000_0013;
   logic mr_req, mr_cs, mr_ack = 1'b0;
   logic [2:0] mr_rate = 3'd0;
   logic alert_clr = 1'b0, defer_done = 1'b0;
   logic [2:0] temp_level;
   logic alert, relax_pend, shutdown;
   logic [REG_W-1:0] out_refctl, out_tim1, out_tim3;

   logic [2:0] code_cs0 = 3'd3, code_cs1 = 3'd3;
   int n_chk = 0, n_err = 0;
   int n_cs0_starts = 0, n_cs1_reads = 0;
   logic req_d = 1'b0;
   bit done = 0;

   always #2 clk = ~clk;

   dram_derate_mon #(.REG_W(REG_W), .CNT_W(CNT_W)) u_dram_derate_mon (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .poll_interval(poll_interval),
      .cs1_used(cs1_used), .ext_temp_ok(ext_temp_ok), .is_lpddr2(is_lpddr2),
      .nom_refctl(nom_refctl), .nom_tim1(nom_tim1), .nom_tim3(nom_tim3),
      .drt_refctl(drt_refctl), .drt_tim1(drt_tim1), .drt_tim3(drt_tim3),
      .mr_req(mr_req), .mr_cs(mr_cs), .mr_ack(mr_ack), .mr_rate(mr_rate),
      .alert_clr(alert_clr), .defer_done(defer_done), .temp_level(temp_level),
      .alert(alert), .relax_pend(relax_pend), .shutdown(shutdown),
      .out_refctl(out_refctl), .out_tim1(out_tim1), .out_tim3(out_tim3));

   // memory stand-in: one-cycle acknowledge per request, plus pass counters
   always @(negedge clk) begin
      if (mr_req && !req_d && !mr_cs) n_cs0_starts++;
      if (mr_ack && mr_cs) n_cs1_reads++;
      req_d <= mr_req;
      if (mr_req && !mr_ack) begin
         mr_ack  <= 1'b1;
         mr_rate <= mr_cs ? code_cs1 : code_cs0;
      end else begin
         mr_ack <= 1'b0;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_word(input int idx, input int lvl, input bit lp);
      logic [31:0] nomv, drtv;
      int floor_lvl;
      nomv = (idx == 0) ? 32'hA000_0010 : (idx == 1) ? 32'hA000_0011 : 32'hA000_0013;
      drtv = (idx == 0) ? 32'hD000_0010 : (idx == 1) ? 32'hD000_0011 : 32'hD000_0013;
      floor_lvl = (idx == 0) ? 5 : 6;
      return (lp && lvl >= floor_lvl && lvl <= 6) ? drtv : nomv;
   endfunction

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   // model state
   int m_lvl = 3, m_app = 3;
   bit m_alert = 0, m_pend = 0;

   task automatic settle(input logic [2:0] c0, input logic [2:0] c1);
      int raw, cand;
      poll_interval = '0;
      cycles(10);
      code_cs0 = c0; code_cs1 = c1;
      ref_tick = 1'b1;
      poll_interval = 16'd2;
      cycles(24);
      poll_interval = '0;
      cycles(10);
      raw = (cs1_used && c1 > c0) ? int'(c1) : int'(c0);   // R3
      if (raw < 3) raw = 3;                                 // R4
      if (raw != 4) begin                                   // R5
         cand = (!ext_temp_ok && raw >= 5) ? 7 : raw;       // R6
         if (cand != m_lvl) begin
            m_alert = 1;
            if (cand < m_lvl || cand == 7) m_pend = 1;      // R9
            else begin m_app = cand; m_pend = 0; end        // R8
            m_lvl = cand;
         end
      end
   endtask

   task automatic check_state(input string ctx);
      chk({"R3/R4/R5 level ", ctx}, 32'(temp_level), 32'(m_lvl));
      chk({"R7 alert ", ctx}, 32'(alert), 32'(m_alert));
      chk({"R9 relax_pend ", ctx}, 32'(relax_pend), 32'(m_pend));
      chk({"R6 shutdown ", ctx}, 32'(shutdown), 32'(m_lvl == 7));
      chk({"R10 refctl ", ctx}, out_refctl, exp_word(0, m_app, is_lpddr2));
      chk({"R10 tim1 ", ctx}, out_tim1, exp_word(1, m_app, is_lpddr2));
      chk({"R10 tim3 ", ctx}, out_tim3, exp_word(2, m_app, is_lpddr2));
   endtask

   task automatic ack_all();
      alert_clr = 1'b1; defer_done = 1'b1;
      cycles(1);
      alert_clr = 1'b0; defer_done = 1'b0;
      cycles(1);
      m_alert = 0;
      if (m_pend) begin m_app = m_lvl; m_pend = 0; end
      chk("R7 alert cleared", 32'(alert), 32'd0);
      chk("R9 commit applied", out_refctl, exp_word(0, m_app, is_lpddr2));
   endtask

   initial begin
      int base;
      cycles(3);
      rst_n = 1'b1;
      cycles(2);
      // R12 reset state
      chk("R12 level", 32'(temp_level), 32'd3);
      chk("R12 alert", 32'(alert), 32'd0);
      chk("R12 pend", 32'(relax_pend), 32'd0);
      chk("R12 shutdown", 32'(shutdown), 32'd0);
      chk("R12 req", 32'(mr_req), 32'd0);
      chk("R12 refctl", out_refctl, 32'hA000_0010);

      // near-exhaustive sweep over flags and code pairs
      for (int e = 1; e >= 0; e--) begin
         for (int u = 0; u < 2; u++) begin
            ext_temp_ok = e[0];
            cs1_used    = u[0];
            for (int a = 0; a < 8; a++) begin
               for (int b = 0; b < 8; b++) begin
                  settle(3'(a), 3'(b));
                  check_state($sformatf("e=%0d u=%0d c0=%0d c1=%0d", e, u, a, b));
                  ack_all();
               end
            end
         end
      end

      // R2: no chip select 1 reads when it is not populated
      ext_temp_ok = 1'b1;
      cs1_used = 1'b0;
      base = n_cs1_reads;
      settle(3'd5, 3'd7);
      chk("R2 cs1 reads when unused", 32'(n_cs1_reads - base), 32'd0);
      chk("R3 cs1 ignored when unused", 32'(temp_level), 32'(m_lvl));
      ack_all();
      cs1_used = 1'b1;
      base = n_cs1_reads;
      settle(3'd5, 3'd6);
      chk("R2 cs1 read when used", 32'(n_cs1_reads > base), 32'd1);
      check_state("R8 rise 5->6");
      ack_all();

      // R11: non-LPDDR2 keeps nominal words at a derate level
      is_lpddr2 = 1'b0;
      cycles(2);
      chk("R11 refctl nominal", out_refctl, 32'hA000_0010);
      chk("R11 tim1 nominal", out_tim1, 32'hA000_0011);
      chk("R11 tim3 nominal", out_tim3, 32'hA000_0013);
      is_lpddr2 = 1'b1;
      cycles(2);
      chk("R11 derated back", out_tim1, 32'hD000_0011);

      // R1: zero interval issues no reads
      poll_interval = '0;
      ref_tick = 1'b1;
      cycles(10);
      base = n_cs0_starts;
      cycles(50);
      chk("R1 zero interval no polls", 32'(n_cs0_starts - base), 32'd0);
      // R1: interval 3 with 30 sparse ticks gives 10 passes
      ref_tick = 1'b0;
      cycles(4);
      poll_interval = 16'd3;
      base = n_cs0_starts;
      for (int t = 0; t < 30; t++) begin
         ref_tick = 1'b1; cycles(1);
         ref_tick = 1'b0; cycles(9);
      end
      cycles(20);
      chk("R1 passes per ticks", 32'(n_cs0_starts - base), 32'd10);

      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule